// File: doc/BRIEF.md
# Dual Cross-Checking Watchdog Enable

This block produces a second, active-high telescope enable that sits beside the main active-low enable. Because the two paths use opposite polarities, one wire stuck at either level cannot hold both of them in the enabling state. The backup enable is asserted only when three conditions hold together: the system is out of reset, the amplifier/brake enable request is high, and both clock supervisors report healthy.

There are two supervisors. The host watchdog runs on the system clock. A high-to-low transition on the host heartbeat retriggers it, and it expires when no such transition arrives within a window that defaults to 600 ms. The cross-clock watchdog counts host heartbeat falls that arrive after the last rising edge of the local slow clock. It expires when a set number of them pass without a local edge. Between them, the two supervisors catch the loss of either clock.

The expiry flags of the two supervisors are OR-ed into one fault term. When a supervisor drops from healthy to expired, the block latches `wd_fault`, and that latch holds the enable off until the next reset. Immediately after reset both supervisors are in the expired state. This blocks the enable without raising `wd_fault`, and each supervisor clears once its own clock has shown its first valid edge.

Top module: `tel_guard_enable`

## Requirements
- R1: While `rst_n` is 0, `guard_en` is 0 in the same cycle, and `wd_fault` reads 0 after the next clock edge.
- R2: After reset is released, both supervisors are expired. `guard_en` stays 0 and `wd_fault` stays 0 until the first host heartbeat fall and the first local clock rising edge have been processed. The host fall takes effect at the third rising clock edge that samples the heartbeat low.
- R3: `guard_en` is the AND of `rst_n`, `amp_brake_en` and the absence of any expiry or latched fault. `amp_brake_en` acts on `guard_en` within the same cycle and never sets `wd_fault`.
- R4: Only high-to-low heartbeat transitions retrigger the host watchdog. A rising transition does not extend the window, and falls spaced at most `WIN_CYC` system cycles apart keep the host watchdog healthy.
- R5: Take edge k as the first clock edge that samples the heartbeat low after a fall. If no later fall is processed by edge k+2+`WIN_CYC`, then at that edge the host watchdog expires, `guard_en` goes to 0 and `wd_fault` goes to 1. `WIN_CYC` equals `SYS_HZ`/1000 × `WIN_MS`.
- R6: The `HB_WIN`-th host heartbeat fall processed after the last local clock rising edge expires the cross-clock watchdog, in the same cycle that fall is processed. At that point `guard_en` goes to 0 and `wd_fault` goes to 1.
- R7: Once `wd_fault` is 1, it and the blocked `guard_en` persist through resumed heartbeats and a resumed local clock, until `rst_n` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, also the reset term of the enable |
| hb_in | input | 1 | Host heartbeat, asynchronous; falls retrigger |
| slow_clk_in | input | 1 | Local slow oscillator, asynchronous; rising edges supervised |
| amp_brake_en | input | 1 | Amplifier/brake enable request, active high |
| guard_en | output | 1 | Redundant telescope enable, active high |
| wd_fault | output | 1 | Latched watchdog fault, 1 = timer fault |

## Verification
A heartbeat fall first sampled at edge k acts at edge k+2. Host expiry is therefore due exactly at edge k+2+`WIN_CYC`, and a cross-clock expiry appears at edge k+2 of its `HB_WIN`-th fall. The bench drives every input on the falling clock edge. It numbers edges from the one that samples each fall, and reads outputs at the next falling edge. Gap sweeps from `WIN_CYC`-2 to `WIN_CYC`+2 compare every cycle with an expiry edge worked out arithmetically. `rst_n` and `amp_brake_en` are combinational terms of `guard_en`, so their effect is read shortly after they are driven, within the same cycle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic { EDGE_RISE = 1'b0, EDGE_FALL = 1'b1 } edge_kind_e;
endpackage

// File: rtl/tg_edge_sync.sv
module tg_edge_sync #(
  parameter tg_pkg::edge_kind_e KIND = tg_pkg::EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  generate
    if (KIND == tg_pkg::EDGE_FALL) begin : g_fall
      assign pulse = prev_q & ~sync_q;
    end else begin : g_rise
      assign pulse = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/tg_host_wdog.sv
module tg_host_wdog #(
  parameter int WIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired,
  output logic trip
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      exp_q <= 1'b1;
    end else if (kick) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = exp_q;
  assign trip    = ~exp_q & ~kick & (cnt_q == LAST);

  // R4
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!expired && cnt_q == '0));
  // R5
  window_end_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!expired && !kick && cnt_q == LAST) |=> expired);
endmodule

// File: rtl/tg_xclk_wdog.sv
module tg_xclk_wdog #(
  parameter int HB_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic local_edge,
  input  logic host_tick,
  output logic expired,
  output logic trip
);
  localparam int CW = $clog2(HB_WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(HB_WIN - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      exp_q <= 1'b1;
    end else if (local_edge) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (host_tick) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = exp_q;
  assign trip    = ~exp_q & ~local_edge & host_tick & (cnt_q == LAST);

  // R6
  local_edge_heals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_edge |=> !expired);
  // R6
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_edge && !host_tick) |=> ($stable(expired) && $stable(cnt_q)));
endmodule

// File: rtl/tel_guard_enable.sv
module tel_guard_enable #(
  parameter int SYS_HZ = 50_000_000,
  parameter int WIN_MS = 600,
  parameter int HB_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  input  logic slow_clk_in,
  input  logic amp_brake_en,
  output logic guard_en,
  output logic wd_fault
);
  localparam int WIN_CYC = (SYS_HZ / 1000) * WIN_MS;

  logic hb_fall, lc_rise;
  logic host_exp, host_trip, xclk_exp, xclk_trip;
  logic fault_q;

  tg_edge_sync #(.KIND(tg_pkg::EDGE_FALL)) u_hb_sync (
    .clk(clk), .rst_n(rst_n), .din(hb_in), .pulse(hb_fall));

  tg_edge_sync #(.KIND(tg_pkg::EDGE_RISE)) u_lc_sync (
    .clk(clk), .rst_n(rst_n), .din(slow_clk_in), .pulse(lc_rise));

  tg_host_wdog #(.WIN_CYC(WIN_CYC)) u_host (
    .clk(clk), .rst_n(rst_n), .kick(hb_fall),
    .expired(host_exp), .trip(host_trip));

  tg_xclk_wdog #(.HB_WIN(HB_WIN)) u_xclk (
    .clk(clk), .rst_n(rst_n), .local_edge(lc_rise), .host_tick(hb_fall),
    .expired(xclk_exp), .trip(xclk_trip));

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_q | host_trip | xclk_trip;
  end

  assign wd_fault = fault_q;
  assign guard_en = rst_n & amp_brake_en & ~(host_exp | xclk_exp | fault_q);

  // R1
  reset_blocks_chk: assert property (@(posedge clk) !rst_n |-> !guard_en);
  // R3
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fault || !amp_brake_en) |-> !guard_en);
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fault |=> wd_fault);
  // R5
  trip_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_trip || xclk_trip) |=> (wd_fault && !guard_en));
endmodule

// File: tb/test_tel_guard_enable.sv
module test_tel_guard_enable;
  localparam int SYS_HZ = 1000;
  localparam int WIN_MS = 20;
  localparam int HB_WIN = 3;
  localparam int WIN    = (SYS_HZ / 1000) * WIN_MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_in = 1'b0;
  logic slow_clk_in = 1'b0;
  logic amp_brake_en = 1'b0;
  logic guard_en, wd_fault;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit lc_run = 1'b0;
  int lc_cnt = 0;

  always #10 clk = ~clk;

  tel_guard_enable #(.SYS_HZ(SYS_HZ), .WIN_MS(WIN_MS), .HB_WIN(HB_WIN)) i_tel_guard_enable (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .slow_clk_in(slow_clk_in),
    .amp_brake_en(amp_brake_en), .guard_en(guard_en), .wd_fault(wd_fault));

  always @(negedge clk) begin
    if (lc_run) begin
      lc_cnt++;
      if (lc_cnt == 3) begin
        lc_cnt = 0;
        slow_clk_in = ~slow_clk_in;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bring_up();
    @(negedge clk);
    rst_n = 1'b0; hb_in = 1'b0; amp_brake_en = 1'b1; lc_run = 1'b1;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (8) step();
    hb_in = 1'b1; step(); hb_in = 1'b0;
    repeat (6) step();
    chk("R2 healthy after bring-up", guard_en, 1'b1);
  endtask

  initial begin
    repeat (2) step();
    // R1: reset state
    chk("R1 guard_en in reset", guard_en, 1'b0);
    chk("R1 wd_fault in reset", wd_fault, 1'b0);

    // R2: expired start until first edges
    amp_brake_en = 1'b1; lc_run = 1'b1;
    step(); rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      chk("R2 blocked before heartbeat", guard_en, 1'b0);
      chk("R2 no fault before heartbeat", wd_fault, 1'b0);
    end
    hb_in = 1'b1; step(); hb_in = 1'b0;
    step(); chk("R2 after edge k", guard_en, 1'b0);
    step(); chk("R2 after edge k+1", guard_en, 1'b0);
    step(); chk("R2 after edge k+2", guard_en, 1'b1);

    // R3: enable request gating
    bring_up();
    amp_brake_en = 1'b0; #1;
    chk("R3 request low", guard_en, 1'b0);
    step(); chk("R3 request low no fault", wd_fault, 1'b0);
    amp_brake_en = 1'b1; #1;
    chk("R3 request high", guard_en, 1'b1);

    // R4 / R5: gap sweep around the window
    for (int p = WIN - 2; p <= WIN + 2; p++) begin
      bring_up();
      hb_in = 1'b1; step(); hb_in = 1'b0;
      for (int j = 1; j <= WIN + 6; j++) begin
        bit expd;
        step();
        expd = (p > WIN) && (j - 1 >= WIN + 2);
        chk(p > WIN ? "R5 gap expiry" : "R4 gap within window", guard_en, !expd);
        chk(p > WIN ? "R5 gap fault" : "R4 gap no fault", wd_fault, expd);
        if (j == p - 1) hb_in = 1'b1;
        if (j == p) hb_in = 1'b0;
      end
    end

    // R4: a rising transition does not retrigger
    bring_up();
    hb_in = 1'b1; step(); hb_in = 1'b0;
    for (int j = 1; j <= WIN + 3; j++) begin
      step();
      if (j == 5) hb_in = 1'b1;
      if (j == WIN + 2) chk("R4 rise ignored, before expiry", guard_en, 1'b1);
      if (j == WIN + 3) begin
        chk("R4 rise ignored, expired", guard_en, 1'b0);
        chk("R4 rise ignored, fault", wd_fault, 1'b1);
      end
    end
    hb_in = 1'b0;

    // R6: local clock loss
    bring_up();
    lc_run = 1'b0;
    repeat (6) step();
    for (int n = 1; n <= HB_WIN; n++) begin
      hb_in = 1'b1; step(); hb_in = 1'b0;
      step(); step();
      chk("R6 before fall processed", guard_en, 1'b1);
      step();
      chk("R6 local loss enable", guard_en, n < HB_WIN);
      chk("R6 local loss fault", wd_fault, n == HB_WIN);
      repeat (6) step();
    end

    // R7: fault latch survives recovery
    lc_run = 1'b1;
    for (int n = 0; n < 6; n++) begin
      hb_in = 1'b1; step(); hb_in = 1'b0;
      repeat (9) step();
      chk("R7 fault held", wd_fault, 1'b1);
      chk("R7 enable held off", guard_en, 1'b0);
    end
    rst_n = 1'b0; #1;
    chk("R1 reset drops enable at once", guard_en, 1'b0);
    step();
    chk("R7 reset clears fault", wd_fault, 1'b0);
    chk("R1 enable low in reset", guard_en, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule